// File: doc/BRIEF.md
# Per-Channel Gated Interrupt Status

This block holds an interrupt-enable word and an interrupt-status byte for each of five host channels and drives one shared level interrupt line toward the host. A command state machine elsewhere in the chip reports events as single-cycle pulses. Each pulse carries a channel number and a set of event bits: data-available, status-valid, locality-change and command-ready. The block latches an event bit only when that channel has its global enable set and has enabled that event bit. Latching an event raises the shared line.

Host software changes the enable word and clears status bits through a register write port. Every write carries the channel it was issued from. Only writes from the channel that currently owns the interface take effect. A combinational read port returns any channel's enable word or status. It also returns the interrupt vector, which is a fixed parameter and cannot be written.

Top module: `chan_irq_status`

## Requirements
- R1: After reset every channel's enable word reads 0x0000_0008 (polarity field, bits 4:3, holding the low-level code 2'b01), every status reads 0, and `irq` is low.
- R2: An event pulse for channel c sets, in the next cycle, status bits equal to `ev_bits & enable[7:0]` restricted to the event bits. This happens only when enable bit 31 (global enable) of channel c is set. In that case `irq` is high from the next cycle. Event bits: bit 0 data-available, bit 1 status-valid, bit 2 locality-change, bit 7 command-ready.
- R3: An event whose bits are all disabled for the channel, or that targets a channel with global enable clear, leaves all status and `irq` unchanged.
- R4: An event pulse with a channel number of 5 or more means no channel. It changes no status and does not touch `irq`.
- R5: Enable and status writes (`wr_sel` 0 = enable, 1 = status) whose `wr_ch` differs from `active_ch` have no effect. This includes every write while `active_ch` is 5 or more.
- R6: An enable write replaces the bytes selected by `wr_strb` (bit n covers data bits 8n+7:8n). Within those bytes, only bits 31, 4:3, 7 and 2:0 can be set; every other bit in them reads 0.
- R7: A status write clears each status bit for which the written, strobed value holds a 1 on an event bit. Ones on other bit positions have no effect.
- R8: The line drops when a status write takes a channel's status from nonzero to zero. This holds even if another channel still has status pending. A clear that leaves bits set keeps `irq` high.
- R9: Reads with `rd_sel` 2 return the parameter `VECTOR`, and writes with `wr_sel` 2 change nothing.
- R10: When an event and a status write reach the same channel in one cycle, the event's bits are set after the clear, and `irq` is high next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_ch | input | CH_W | Channel that owns the interface; values >= NUM_CH mean none |
| ev_valid | input | 1 | Event pulse valid |
| ev_ch | input | CH_W | Channel the event targets |
| ev_bits | input | 8 | Event bits of the pulse |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W | Channel that issued the write |
| wr_sel | input | 2 | Register select: 0 enable, 1 status, 2 vector |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte-lane strobes of the write |
| rd_ch | input | CH_W | Channel to read |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Shared level interrupt line |

## Verification
The bench uses the defaults NUM_CH = 5 and CH_W = 3, and sets VECTOR to 11 so the vector read is a nonzero value. With three channel bits, the numbers 5, 6 and 7 can be driven on `ev_ch` and `active_ch`, which exercises the no-channel paths for events and for ownership. Five channels are enough for one owner, a pending second channel and several non-owners. That mix is what the shared-line drop and the ignored-write cases need.

// File: rtl/cis_pkg.sv
package cis_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int          DATA_W      = 32;
  localparam int          EVT_W       = 8;
  localparam int          GLOBAL_BIT  = 31;
  localparam logic [7:0]  EVT_SUPPORT = 8'h87;
  localparam logic [31:0] EN_WRITABLE = 32'h8000_009F;
  localparam logic [31:0] EN_RESET    = 32'h0000_0008;

  function automatic logic [31:0] lane_mask(input logic [3:0] strb);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{strb[b]}};
    return m;
  endfunction

  function automatic logic [31:0] enable_merge(input logic [31:0] cur,
                                               input logic [31:0] wdata,
                                               input logic [3:0]  strb);
    logic [31:0] m;
    m = lane_mask(strb);
    return (cur & ~m) | (wdata & m & EN_WRITABLE);
  endfunction

  function automatic logic [7:0] gate_events(input logic [31:0] en,
                                             input logic [7:0]  bits);
    return en[GLOBAL_BIT] ? (bits & en[7:0] & EVT_SUPPORT) : 8'h00;
  endfunction
endpackage

// File: rtl/cis_bank.sv
module cis_bank
  import cis_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_hit,
  input  logic [7:0]  ev_bits,
  input  logic        en_wr,
  input  logic        st_wr,
  input  logic [31:0] wdata,
  input  logic [3:0]  wstrb,
  output logic [31:0] en_q,
  output logic [7:0]  st_q,
  output logic        latched,
  output logic        emptied
);
  logic [7:0] set_bits;
  logic [7:0] clr_bits;
  logic [7:0] st_after_clr;

  assign set_bits     = ev_hit ? gate_events(en_q, ev_bits) : 8'h00;
  assign clr_bits     = st_wr ? (wdata[7:0] & lane_mask(wstrb)[7:0] & EVT_SUPPORT) : 8'h00;
  assign st_after_clr = st_q & ~clr_bits;
  assign latched      = |set_bits;
  assign emptied      = (|clr_bits) && (|st_q) && (st_after_clr == 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= EN_RESET;
      st_q <= 8'h00;
    end else begin
      if (en_wr) en_q <= enable_merge(en_q, wdata, wstrb);
      st_q <= st_after_clr | set_bits;
    end
  end

  // R3: with global enable clear and no status write, status holds
  a_r3_no_latch_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[GLOBAL_BIT] && !st_wr) |=> (st_q == $past(st_q)));
  // R7: a status write never sets bits
  a_r7_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !ev_hit) |=> ((st_q & ~$past(st_q)) == 8'h00));
  // R2: a latched event leaves its bits set
  a_r2_bits_seen: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> (st_q != 8'h00));
endmodule

// File: rtl/cis_line.sv
module cis_line (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_any,
  input  logic lower_any,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (raise_any) irq_q <= 1'b1;
    else if (lower_any) irq_q <= 1'b0;
  end

  // R2: a latched event drives the line high next cycle
  a_r2_raise: assert property (@(posedge clk) disable iff (!rst_n)
    raise_any |=> irq_q);
  // R8: an emptying clear without a new event drops the line
  a_r8_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (lower_any && !raise_any) |=> !irq_q);
endmodule

// File: rtl/chan_irq_status.sv
module chan_irq_status
  import cis_pkg::*;
#(
  parameter int          NUM_CH = 5,
  parameter int          CH_W   = 3,
  parameter logic [31:0] VECTOR = 32'd0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] active_ch,
  input  logic            ev_valid,
  input  logic [CH_W-1:0] ev_ch,
  input  logic [7:0]      ev_bits,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [1:0]      wr_sel,
  input  logic [31:0]     wr_data,
  input  logic [3:0]      wr_strb,
  input  logic [CH_W-1:0] rd_ch,
  input  logic [1:0]      rd_sel,
  output logic [31:0]     rd_data,
  output logic            irq
);
  localparam int ALL_W = NUM_CH * DATA_W;
  localparam int STS_W = NUM_CH * EVT_W;

  reg_sel_e         wsel;
  reg_sel_e         rsel;
  logic             owner_ok;
  logic [31:0]      en_q   [NUM_CH];
  logic [7:0]       st_q   [NUM_CH];
  logic [NUM_CH-1:0] latched;
  logic [NUM_CH-1:0] emptied;
  logic [ALL_W-1:0] en_all;
  logic [STS_W-1:0] st_all;

  assign wsel     = reg_sel_e'(wr_sel);
  assign rsel     = reg_sel_e'(rd_sel);
  assign owner_ok = wr_en && (wr_ch == active_ch) && (int'(active_ch) < NUM_CH);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_bank
    logic hit_i;
    logic mine_i;
    assign hit_i  = ev_valid && (int'(ev_ch) == i);
    assign mine_i = owner_ok && (int'(wr_ch) == i);
    cis_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_hit  (hit_i),
      .ev_bits (ev_bits),
      .en_wr   (mine_i && (wsel == SEL_ENABLE)),
      .st_wr   (mine_i && (wsel == SEL_STATUS)),
      .wdata   (wr_data),
      .wstrb   (wr_strb),
      .en_q    (en_q[i]),
      .st_q    (st_q[i]),
      .latched (latched[i]),
      .emptied (emptied[i])
    );
    assign en_all[i*DATA_W +: DATA_W] = en_q[i];
    assign st_all[i*EVT_W +: EVT_W]   = st_q[i];
  end

  cis_line u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise_any (|latched),
    .lower_any (|emptied),
    .irq_q     (irq)
  );

  always_comb begin
    rd_data = 32'h0;
    if (rsel == SEL_VECTOR) begin
      rd_data = VECTOR;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (int'(rd_ch) == i) begin
          if (rsel == SEL_ENABLE)      rd_data = en_q[i];
          else if (rsel == SEL_STATUS) rd_data = {24'h0, st_q[i]};
        end
      end
    end
  end

  // R4: an event for no channel changes no status
  a_r4_no_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && (int'(ev_ch) >= NUM_CH) && !wr_en) |=> $stable(st_all));
  // R5: writes from a non-owner leave every enable word alone
  a_r5_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_ch != active_ch)) |=> $stable(en_all));
  // R9: vector writes change no enable word
  a_r9_vector_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wsel == SEL_VECTOR)) |=> $stable(en_all));
endmodule

// File: tb/chan_irq_status_test.sv
module chan_irq_status_test;
  localparam int          PERIOD = 10;
  localparam logic [31:0] VEC    = 32'd11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  active_ch = 3'd7;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_ch = 3'd0;
  logic [7:0]  ev_bits = 8'h0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_ch = 3'd0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'h0;
  logic [3:0]  wr_strb = 4'h0;
  logic [2:0]  rd_ch = 3'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] q_exp[$];
  string       q_tag[$];
  bit          q_line[$];
  event        smp_ev;

  always #(PERIOD/2) clk = ~clk;

  chan_irq_status #(.NUM_CH(5), .CH_W(3), .VECTOR(VEC)) uut (
    .clk(clk), .rst_n(rst_n), .active_ch(active_ch), .ev_valid(ev_valid),
    .ev_ch(ev_ch), .ev_bits(ev_bits), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_sel(wr_sel), .wr_data(wr_data), .wr_strb(wr_strb), .rd_ch(rd_ch),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(smp_ev);
      while (q_exp.size() > 0) begin
        logic [31:0] e;
        logic [31:0] a;
        string t;
        bit ln;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        ln = q_line.pop_front();
        a = ln ? {31'h0, irq} : rd_data;
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s actual=0x%08h expected=0x%08h", t, a, e);
        end
      end
    end
  end

  task automatic expect_rd(input logic [2:0] ch, input logic [1:0] sel,
                           input logic [31:0] exp, input string tag);
    rd_ch = ch;
    rd_sel = sel;
    #1;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    q_line.push_back(1'b0);
    ->smp_ev;
    #1;
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    #1;
    q_exp.push_back({31'h0, exp});
    q_tag.push_back(tag);
    q_line.push_back(1'b1);
    ->smp_ev;
    #1;
  endtask

  task automatic do_write(input logic [2:0] ch, input logic [1:0] sel,
                          input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch; wr_sel = sel; wr_data = d; wr_strb = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_event(input logic [2:0] ch, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1; ev_ch = ch; ev_bits = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_rd(3'd0, 2'd0, 32'h0000_0008, "R1 enable reset");
    expect_rd(3'd4, 2'd1, 32'h0, "R1 status reset");
    expect_irq(1'b0, "R1 line reset");
    // R9 vector constant, writes ignored
    active_ch = 3'd2;
    expect_rd(3'd0, 2'd2, VEC, "R9 vector read");
    do_write(3'd2, 2'd2, 32'hFFFF_FFFF, 4'hF);
    expect_rd(3'd0, 2'd2, VEC, "R9 vector after write");
    expect_rd(3'd2, 2'd0, 32'h0000_0008, "R9 enable untouched");
    // R6 enable writable bits and lanes
    do_write(3'd2, 2'd0, 32'hFFFF_FFFF, 4'hF);
    expect_rd(3'd2, 2'd0, 32'h8000_009F, "R6 writable mask");
    do_write(3'd2, 2'd0, 32'h0, 4'h1);
    expect_rd(3'd2, 2'd0, 32'h8000_0000, "R6 low lane only");
    do_write(3'd2, 2'd0, 32'h0, 4'h8);
    expect_rd(3'd2, 2'd0, 32'h0, "R6 high lane only");
    do_write(3'd2, 2'd0, 32'h8000_0005, 4'hF);
    expect_rd(3'd2, 2'd0, 32'h8000_0005, "R6 full write");
    // R5 foreign enable write
    do_write(3'd1, 2'd0, 32'hFFFF_FFFF, 4'hF);
    expect_rd(3'd1, 2'd0, 32'h0000_0008, "R5 foreign enable");
    // R2 latch
    do_event(3'd2, 8'h01);
    expect_rd(3'd2, 2'd1, 32'h01, "R2 status set");
    expect_irq(1'b1, "R2 line raised");
    // R3 disabled bit and disabled channel
    do_event(3'd2, 8'h02);
    expect_rd(3'd2, 2'd1, 32'h01, "R3 disabled bit");
    do_event(3'd1, 8'h01);
    expect_rd(3'd1, 2'd1, 32'h00, "R3 global off");
    // R8 partial clear keeps line, R7 unsupported bits
    do_event(3'd2, 8'h04);
    expect_rd(3'd2, 2'd1, 32'h05, "R2 second bit");
    do_write(3'd2, 2'd1, 32'h01, 4'hF);
    expect_rd(3'd2, 2'd1, 32'h04, "R7 clear one");
    expect_irq(1'b1, "R8 line held");
    do_write(3'd2, 2'd1, 32'h78, 4'hF);
    expect_rd(3'd2, 2'd1, 32'h04, "R7 unsupported ignored");
    do_write(3'd2, 2'd1, 32'h04, 4'h2);
    expect_rd(3'd2, 2'd1, 32'h04, "R7 lane masked");
    do_write(3'd2, 2'd1, 32'h04, 4'hF);
    expect_rd(3'd2, 2'd1, 32'h00, "R7 cleared");
    expect_irq(1'b0, "R8 line dropped");
    // R4 no channel
    do_event(3'd5, 8'hFF);
    do_event(3'd7, 8'hFF);
    expect_irq(1'b0, "R4 line untouched");
    expect_rd(3'd2, 2'd1, 32'h00, "R4 status untouched");
    // R5 foreign status write and no owner
    do_event(3'd2, 8'h01);
    do_write(3'd3, 2'd1, 32'hFF, 4'hF);
    expect_rd(3'd2, 2'd1, 32'h01, "R5 foreign clear");
    expect_irq(1'b1, "R5 line kept");
    active_ch = 3'd6;
    do_write(3'd2, 2'd0, 32'h0, 4'hF);
    expect_rd(3'd2, 2'd0, 32'h8000_0005, "R5 no owner");
    // R10 event and clear together
    active_ch = 3'd2;
    @(negedge clk);
    ev_valid = 1'b1; ev_ch = 3'd2; ev_bits = 8'h04;
    wr_en = 1'b1; wr_ch = 3'd2; wr_sel = 2'd1; wr_data = 32'h05; wr_strb = 4'hF;
    @(negedge clk);
    ev_valid = 1'b0; wr_en = 1'b0;
    expect_rd(3'd2, 2'd1, 32'h04, "R10 set after clear");
    expect_irq(1'b1, "R10 line high");
    do_write(3'd2, 2'd1, 32'h04, 4'hF);
    // R8 shared line drops even with another channel pending
    active_ch = 3'd3;
    do_write(3'd3, 2'd0, 32'h8000_0001, 4'hF);
    do_event(3'd3, 8'h01);
    active_ch = 3'd2;
    do_event(3'd2, 8'h01);
    do_write(3'd2, 2'd1, 32'h01, 4'hF);
    expect_irq(1'b0, "R8 shared drop");
    expect_rd(3'd3, 2'd1, 32'h01, "R8 other pending");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule